// File: doc/BRIEF.md
# DDR2 Read Burst Data Sequencer

This block sits on the memory side of a DDR2 device model and services READ commands that the command decoder has already registered. With each READ it captures the bank, the starting column and the auto-precharge flag. It then counts the read latency, which is the sum of the additive and CAS latencies. After that it returns the burst at two data elements per clock, one for each clock edge, and drives the data strobe pair around the data.

Each clock, the storage array is read through a small source port. The block presents a bank and two column addresses, one for the rising-edge element and one for the falling-edge element. The array answers combinationally. Back-to-back READs issued half a burst apart chain into one continuous stream. A BL8 burst can be cut short by a new READ at a four-element boundary. When auto-precharge was requested, a one-clock precharge request for the bank follows the last data of the burst.

The data and strobe outputs are modelled at clock granularity. Each output bus carries the values for the rising-edge half and the falling-edge half of a clock period. An output enable low stands for high impedance.

Top module: `ddr2_rd_burst_seq`

## Requirements
- R1: A READ sampled at rising edge k puts elements 0 and 1 of its burst on `dq_o`, with `dq_oe_o` high, during the clock period after edge k+RL. RL = `al_i` + `cl_i`, with `al_i` in 0..4 and `cl_i` in 3..6.
- R2: Each data clock carries the rising-edge element in `dq_o[DQ_W-1:0]` and the falling-edge element in `dq_o[2*DQ_W-1:DQ_W]`. An isolated burst of BL elements occupies exactly BL/2 consecutive clocks with `dq_oe_o` high. BL is 8 when `bl8_i` is 1 at the READ and 4 otherwise.
- R3: Element e of a burst comes from the latched bank and from column (start & ~(BL-1)) | ((start+e) mod BL). The source addresses are presented in the clock before the data appears on `dq_o`.
- R4: In the clock before the first data of a burst that does not directly follow other data, the strobe preamble is driven: `dqs_oe_o`=1, `dqs_o`=2'b00, `dqs_n_o`=2'b11, `dq_oe_o`=0.
- R5: During every data clock, `dqs_oe_o`=1, `dqs_o`=2'b01 and `dqs_n_o`=2'b10. Bit 0 is the rising-edge half and bit 1 the falling-edge half.
- R6: In the clock after the last data of a burst, when no data follows, the strobe postamble is driven: `dqs_oe_o`=1, `dqs_o`=2'b00, `dq_oe_o`=0.
- R7: In every other clock, `dq_oe_o` and `dqs_oe_o` are both low, and `dq_o`, `dqs_o` and `dqs_n_o` are zero. Whenever `dq_oe_o` is low, `dq_o` is zero.
- R8: A READ issued BL/2 clocks after the previous READ delivers its first elements in the clock right after the previous burst's last elements. No gap and no preamble come between them.
- R9: A BL8 READ without auto-precharge that is followed by a new READ 2 clocks later delivers only its elements 0 to 3. The new burst then follows with no gap.
- R10: When A10 (`ap_i`) was high at the READ, `pre_req_o` is high for exactly one clock, the clock after the burst's final data, with `pre_bank_o` equal to the READ's bank. When `ap_i` was low, `pre_req_o` stays low.
- R11: While `rst_ni` is low, `dq_oe_o`, `dqs_oe_o` and `pre_req_o` are low and `dq_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_cmd_i | input | 1 | Registered READ command strobe |
| bank_i | input | 3 | Bank select of the READ |
| col_i | input | 10 | Starting column of the READ |
| ap_i | input | 1 | Auto-precharge flag (A10) |
| al_i | input | 3 | Additive latency, 0..4 |
| cl_i | input | 3 | CAS latency, 3..6 |
| bl8_i | input | 1 | Burst length 8 when 1, 4 when 0 |
| src_bank_o | output | 3 | Bank address to the data source |
| src_col_rise_o | output | 10 | Column of the rising-edge element |
| src_col_fall_o | output | 10 | Column of the falling-edge element |
| src_rise_i | input | DQ_W | Data for `src_col_rise_o` |
| src_fall_i | input | DQ_W | Data for `src_col_fall_o` |
| dq_o | output | 2*DQ_W | {falling element, rising element} |
| dq_oe_o | output | 1 | Data output enable |
| dqs_o | output | 2 | Strobe level per half clock {fall, rise} |
| dqs_n_o | output | 2 | Complementary strobe per half clock |
| dqs_oe_o | output | 1 | Strobe output enable |
| pre_req_o | output | 1 | One-clock precharge request |
| pre_bank_o | output | 3 | Bank to precharge |

## Verification
The assertions check the strobe framing on every clock. The strobe toggles in each data clock and is held low in every driven clock without data. Every start of data is preceded by a driven strobe, and every end of data is followed by one. The precharge request is a single-clock pulse that comes right after data. Exact latency for each AL/CL pair, the column wrap order, and the choice between seamless chaining and truncation cannot be seen from local signal relations. These can only be shown by the bench's behavioural model, which replays the command history and is compared against the outputs on every clock.

// File: rtl/ddr2_rd_pkg.sv
package ddr2_rd_pkg;
  parameter int BANK_W = 3;
  parameter int COL_W  = 10;

  typedef struct packed {
    logic              vld;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic              ap;
    logic              bl8;
  } rd_cmd_t;
endpackage

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe
  import ddr2_rd_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rd_cmd_t          cmd_i,
  input  logic [LAT_W-1:0] rl_i,
  output rd_cmd_t          tap_o,
  output rd_cmd_t          pre_tap_o
);
  rd_cmd_t stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= cmd_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // tap RL-1 launches the burst, tap RL-2 announces the preamble
  always_comb begin
    tap_o     = '0;
    pre_tap_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == int'(rl_i) - 1) tap_o = stg_q[i];
      if (i == int'(rl_i) - 2) pre_tap_o = stg_q[i];
    end
  end

  p_read_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_q[0].vld |-> !stg_q[1].vld);
endmodule

// File: rtl/rd_col_gen.sv
module rd_col_gen #(
  parameter int COL_W  = 10,
  parameter int LANES  = 2,
  parameter int BEAT_W = 3
) (
  input  logic [COL_W-1:0]             start_col_i,
  input  logic                         bl8_i,
  input  logic [BEAT_W-1:0]            beat_i,
  output logic [LANES-1:0][COL_W-1:0]  col_o
);
  logic [COL_W-1:0] msk;
  logic [COL_W-1:0] first_elem;

  assign msk        = bl8_i ? COL_W'(7) : COL_W'(3);
  assign first_elem = COL_W'(beat_i) * COL_W'(LANES);

  // wrap within the burst-aligned block
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign col_o[g] = (start_col_i & ~msk) |
                      ((start_col_i + first_elem + COL_W'(g)) & msk);
  end
endmodule

// File: rtl/rd_burst_ctl.sv
module rd_burst_ctl
  import ddr2_rd_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int LANES  = 2,
  parameter int BEAT_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  rd_cmd_t                tap_i,
  input  rd_cmd_t                pre_tap_i,
  input  logic [LANES*DQ_W-1:0]  data_i,
  output rd_cmd_t                sel_o,
  output logic [BEAT_W-1:0]      beat_o,
  output logic [LANES*DQ_W-1:0]  dq_o,
  output logic                   dq_oe_o,
  output logic [1:0]             dqs_o,
  output logic                   dqs_oe_o,
  output logic                   pre_req_o,
  output logic [BANK_W-1:0]      pre_bank_o
);
  localparam logic [BEAT_W-1:0] LAST_BL4 = BEAT_W'(4 / LANES - 1);
  localparam logic [BEAT_W-1:0] LAST_BL8 = BEAT_W'(8 / LANES - 1);

  rd_cmd_t           held_q;
  logic [BEAT_W-1:0] beat_q;
  logic              busy_q, last_q, last_ap_q;
  logic [BANK_W-1:0] ap_bank_q;
  logic              emit, last;

  // a launching command overrides the running burst (chain or truncate)
  assign sel_o  = tap_i.vld ? tap_i : held_q;
  assign beat_o = tap_i.vld ? '0 : beat_q;
  assign emit   = tap_i.vld | busy_q;
  assign last   = beat_o == (sel_o.bl8 ? LAST_BL8 : LAST_BL4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q     <= '0;
      beat_q     <= '0;
      busy_q     <= 1'b0;
      last_q     <= 1'b0;
      last_ap_q  <= 1'b0;
      ap_bank_q  <= '0;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
      dqs_o      <= 2'b00;
      dqs_oe_o   <= 1'b0;
      pre_req_o  <= 1'b0;
      pre_bank_o <= '0;
    end else begin
      pre_req_o  <= last_ap_q;
      pre_bank_o <= ap_bank_q;
      if (emit) begin
        held_q    <= sel_o;
        beat_q    <= beat_o + 1'b1;
        busy_q    <= !last;
        last_q    <= last;
        last_ap_q <= last & sel_o.ap;
        if (last & sel_o.ap) ap_bank_q <= sel_o.bank;
        dq_o      <= data_i;
        dq_oe_o   <= 1'b1;
        dqs_o     <= 2'b01;
        dqs_oe_o  <= 1'b1;
      end else begin
        busy_q    <= 1'b0;
        last_q    <= 1'b0;
        last_ap_q <= 1'b0;
        dq_o      <= '0;
        dq_oe_o   <= 1'b0;
        dqs_o     <= 2'b00;
        dqs_oe_o  <= pre_tap_i.vld | last_q;  // preamble or postamble
      end
    end
  end

  p_data_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_oe_o && dqs_o == 2'b01));
  p_quiet_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_o && !dq_oe_o) |-> dqs_o == 2'b00);
  p_preamble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_oe_o));
  p_postamble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> dqs_oe_o);
  p_idle_dq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0);
  p_pre_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |=> !pre_req_o);
  p_pre_after_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> $past(dq_oe_o));
endmodule

// File: rtl/ddr2_rd_burst_seq.sv
module ddr2_rd_burst_seq
  import ddr2_rd_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic                 ap_i,
  input  logic [2:0]           al_i,
  input  logic [2:0]           cl_i,
  input  logic                 bl8_i,
  output logic [BANK_W-1:0]    src_bank_o,
  output logic [COL_W-1:0]     src_col_rise_o,
  output logic [COL_W-1:0]     src_col_fall_o,
  input  logic [DQ_W-1:0]      src_rise_i,
  input  logic [DQ_W-1:0]      src_fall_i,
  output logic [2*DQ_W-1:0]    dq_o,
  output logic                 dq_oe_o,
  output logic [1:0]           dqs_o,
  output logic [1:0]           dqs_n_o,
  output logic                 dqs_oe_o,
  output logic                 pre_req_o,
  output logic [BANK_W-1:0]    pre_bank_o
);
  localparam int LANES  = 2;
  localparam int DEPTH  = AL_MAX + CL_MAX;
  localparam int LAT_W  = $clog2(DEPTH + 1);
  localparam int BEAT_W = $clog2(8 / LANES) + 1;

  rd_cmd_t                     cmd, tap, pre_tap, sel;
  logic [LAT_W-1:0]            rl;
  logic [BEAT_W-1:0]           beat;
  logic [LANES-1:0][COL_W-1:0] cols;

  assign cmd = '{vld: rd_cmd_i, bank: bank_i, col: col_i, ap: ap_i, bl8: bl8_i};
  assign rl  = LAT_W'(al_i) + LAT_W'(cl_i);

  rd_lat_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_pipe (
    .clk_i, .rst_ni, .cmd_i(cmd), .rl_i(rl), .tap_o(tap), .pre_tap_o(pre_tap)
  );

  rd_col_gen #(.COL_W(COL_W), .LANES(LANES), .BEAT_W(BEAT_W)) u_cols (
    .start_col_i(sel.col), .bl8_i(sel.bl8), .beat_i(beat), .col_o(cols)
  );

  rd_burst_ctl #(.DQ_W(DQ_W), .LANES(LANES), .BEAT_W(BEAT_W)) u_ctl (
    .clk_i, .rst_ni, .tap_i(tap), .pre_tap_i(pre_tap),
    .data_i({src_fall_i, src_rise_i}), .sel_o(sel), .beat_o(beat),
    .dq_o, .dq_oe_o, .dqs_o, .dqs_oe_o, .pre_req_o, .pre_bank_o
  );

  assign src_bank_o     = sel.bank;
  assign src_col_rise_o = cols[0];
  assign src_col_fall_o = cols[1];
  assign dqs_n_o        = dqs_oe_o ? ~dqs_o : 2'b00;

  p_lat_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i |-> (int'(al_i) <= AL_MAX && int'(cl_i) >= CL_MIN && int'(cl_i) <= CL_MAX));
  p_strobe_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_oe_o |-> (dqs_n_o == ~dqs_o));
endmodule

// File: tb/sim_ddr2_rd_burst_seq.sv
module sim_ddr2_rd_burst_seq;
  localparam int N = 4096;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd = 1'b0, ap = 1'b0, bl8 = 1'b0;
  logic [2:0]  bank = '0, al = '0, cl = 3'd3;
  logic [9:0]  col = '0;
  logic [2:0]  src_bank;
  logic [9:0]  col_r, col_f;
  logic [15:0] d_r, d_f;
  logic [31:0] dq;
  logic        dq_oe, dqs_oe, pre_req;
  logic [1:0]  dqs, dqs_n;
  logic [2:0]  pre_bank;

  int cyc = 0, checks = 0, fails = 0, dq_cnt = 0;
  bit done = 0;
  bit          e_dat [N];
  logic [31:0] e_dq  [N];
  bit          e_pre [N];
  logic [2:0]  e_pb  [N];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mem(input logic [2:0] b, input logic [9:0] c);
    return 16'(({13'd0, b} * 16'h1357) ^ ({6'd0, c} * 16'h00A3) ^ 16'h5A00);
  endfunction

  assign d_r = mem(src_bank, col_r);
  assign d_f = mem(src_bank, col_f);

  ddr2_rd_burst_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_cmd_i(rd), .bank_i(bank), .col_i(col),
    .ap_i(ap), .al_i(al), .cl_i(cl), .bl8_i(bl8), .src_bank_o(src_bank),
    .src_col_rise_o(col_r), .src_col_fall_o(col_f), .src_rise_i(d_r),
    .src_fall_i(d_f), .dq_o(dq), .dq_oe_o(dq_oe), .dqs_o(dqs), .dqs_n_o(dqs_n),
    .dqs_oe_o(dqs_oe), .pre_req_o(pre_req), .pre_bank_o(pre_bank)
  );

  task automatic fail_msg(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s cycle %0d %s: actual %h expected %h", req, cyc, what, act, exp);
  endtask

  // schedule a READ sampled at the next edge (caller is at a negedge)
  task automatic rd_cmd(input logic [2:0] b, input logic [9:0] c, input bit a);
    int k, s, bl;
    logic [9:0] m, ce;
    k  = cyc + 1;
    s  = k + int'(al) + int'(cl);
    bl = bl8 ? 8 : 4;
    m  = 10'(bl - 1);
    for (int t = s; t < s + 10; t++) begin
      e_dat[t] = 0;
      if (t > s) e_pre[t] = 0;
    end
    for (int e = 0; e < bl; e++) begin
      ce = (c & ~m) | ((c + 10'(e)) & m);
      e_dat[s + e/2] = 1;
      if (e % 2 == 0) e_dq[s + e/2][15:0] = mem(b, ce);
      else            e_dq[s + e/2][31:16] = mem(b, ce);
    end
    if (a) begin
      e_pre[s + bl/2] = 1;
      e_pb[s + bl/2]  = b;
    end
    rd = 1'b1; bank = b; col = c; ap = a;
    @(negedge clk);
    rd = 1'b0; ap = 1'b0;
  endtask

  // cycle-accurate comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done && cyc > 0 && cyc < N - 1) begin
      automatic int t = cyc;
      automatic bit x_oe  = e_dat[t];
      automatic bit x_soe = e_dat[t] | e_dat[t+1] | e_dat[t-1];
      automatic logic [1:0] x_dqs = x_oe ? 2'b01 : 2'b00;
      automatic logic [1:0] x_dqn = x_soe ? ~x_dqs : 2'b00;
      automatic logic [31:0] x_dq = x_oe ? e_dq[t] : 32'h0;
      automatic string sreq = x_oe ? "R5" : (e_dat[t+1] ? "R4" : (e_dat[t-1] ? "R6" : "R7"));
      checks++;
      if (dq_oe !== x_oe) fail_msg(x_oe ? "R1" : "R7", "dq_oe", 32'(dq_oe), 32'(x_oe));
      else if (dq !== x_dq) fail_msg(x_oe ? "R3" : "R7", "dq", dq, x_dq);
      else if (dqs_oe !== x_soe) fail_msg(sreq, "dqs_oe", 32'(dqs_oe), 32'(x_soe));
      else if (dqs !== x_dqs || dqs_n !== x_dqn)
        fail_msg(sreq, "dqs/dqs_n", {28'd0, dqs, dqs_n}, {28'd0, x_dqs, x_dqn});
      else if (pre_req !== e_pre[t]) fail_msg("R10", "pre_req", 32'(pre_req), 32'(e_pre[t]));
      else if (pre_req && pre_bank !== e_pb[t]) fail_msg("R10", "pre_bank", 32'(pre_bank), 32'(e_pb[t]));
      if (dq_oe) dq_cnt++;
    end
  end

  task automatic expect_count(input string req, input int exp);
    checks++;
    if (dq_cnt != exp) fail_msg(req, "data clocks", 32'(dq_cnt), 32'(exp));
    dq_cnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      e_dat[i] = 0; e_pre[i] = 0; e_dq[i] = '0; e_pb[i] = '0;
    end
    idle(3);
    // R11 reset state
    checks++;
    if (dq_oe !== 1'b0 || dqs_oe !== 1'b0 || pre_req !== 1'b0 || dq !== '0)
      fail_msg("R11", "reset outputs", {dq_oe, dqs_oe, pre_req}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R1 R2 R3: BL4, RL 3, odd start column
    al = 3'd0; cl = 3'd3; bl8 = 0;
    rd_cmd(3'd1, 10'd5, 0);
    idle(16); expect_count("R2", 2);

    // R3 R10: BL8 wrap at top of column space with auto precharge, RL 6
    al = 3'd2; cl = 3'd4; bl8 = 1;
    rd_cmd(3'd3, 10'h3FD, 1);
    idle(20); expect_count("R2", 4);

    // R8: three chained BL4 reads at RL 10, last with precharge
    al = 3'd4; cl = 3'd6; bl8 = 0;
    rd_cmd(3'd2, 10'd8, 0); idle(1);
    rd_cmd(3'd5, 10'd13, 0); idle(1);
    rd_cmd(3'd7, 10'd2, 1);
    idle(24); expect_count("R8", 6);

    // R8: chained BL8 reads
    al = 3'd1; cl = 3'd3; bl8 = 1;
    rd_cmd(3'd0, 10'd100, 1); idle(3);
    rd_cmd(3'd4, 10'd37, 0);
    idle(20); expect_count("R8", 8);

    // R9: BL8 truncated after four elements
    al = 3'd0; cl = 3'd5; bl8 = 1;
    rd_cmd(3'd6, 10'd21, 0); idle(1);
    rd_cmd(3'd1, 10'd50, 1);
    idle(20); expect_count("R9", 6);

    // R4 R6: one-clock gap, then two-clock gap between BL4 bursts
    al = 3'd1; cl = 3'd4; bl8 = 0;
    rd_cmd(3'd2, 10'd0, 0); idle(2);
    rd_cmd(3'd3, 10'd7, 0); idle(3);
    rd_cmd(3'd4, 10'd10, 1);
    idle(20); expect_count("R2", 6);

    // R7: long idle stays quiet
    idle(20); expect_count("R7", 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule